// File: doc/BRIEF.md
# Sleep Entry and Wake Controller

This block decides when the core clock is stopped for sleep and when it is restarted. A core announces its intent through one-cycle strobes: a wait-for-interrupt strobe, a wait-for-event strobe, or a return from an interrupt handler to thread level while the sleep-on-exit control is set. The controller then drops its clock-gate enable and raises a sleeping status bit. It watches the interrupt request lines, their enable masks and a set of event-mode lines until the wake condition that matches the entry kind appears.

A sleep entered through wait-for-interrupt, or through sleep-on-exit, ends on any enabled interrupt request. A sleep entered through wait-for-event ends on an event. An event is an edge-free pulse on any event line or, when send-event-on-pending is set, a request on an interrupt line whose enable is clear. Event lines set no pending state, so a wake from them needs no clean-up. The wake pulse appears one cycle after the condition is seen. A one-bit event latch remembers events that arrive while the core is awake, so a later wait-for-event strobe falls through instead of sleeping.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After a synchronous reset, clk_en_o is 1, sleeping_o is 0, wake_o is 0, and the event latch is clear, so the first wait-for-event strobe with no event enters sleep.
- R2: While awake, a wfi_i strobe with no enabled interrupt request makes sleeping_o 1 and clk_en_o 0 from the next cycle.
- R3: A cycle with isr_ret_i, ret_thread_i and sleep_on_exit_i all 1 enters sleep of the interrupt kind. If either ret_thread_i or sleep_on_exit_i is 0, no sleep is entered.
- R4: A sleep of the interrupt kind ends only when some line has both irq_req_i and irq_en_i set. Unenabled requests and event lines leave it asleep.
- R5: A sleep of the event kind ends only on an event. An enabled interrupt request alone leaves it asleep.
- R6: An interrupt line with irq_req_i 1 and irq_en_i 0 counts as an event only while sev_on_pend_i is 1.
- R7: The cycle after a wake condition is seen, wake_o is 1 for exactly one cycle. In that same cycle clk_en_o is 1 and sleeping_o is 0.
- R8: An event seen while awake, or during an interrupt-kind sleep, sets the event latch. A wait-for-event strobe clears the latch and enters sleep only if the latch was clear. A wake from an event-kind sleep also clears the latch.
- R9: An enabled interrupt request in the same cycle as any entry strobe cancels the entry. For a wait-for-event entry, an event in the same cycle also cancels it.
- R10: Entry strobes are ignored while asleep. If wfi_i and wfe_i arrive together, the sleep is of the interrupt kind, and a wfe_i in the same cycle as a sleep-on-exit return gives the event kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (free-running) |
| rst | input | 1 | Synchronous active-high reset |
| wfi_i | input | 1 | Wait-for-interrupt strobe |
| wfe_i | input | 1 | Wait-for-event strobe |
| isr_ret_i | input | 1 | Handler return strobe |
| ret_thread_i | input | 1 | Handler return goes to thread level |
| sleep_on_exit_i | input | 1 | Auto-sleep on return to thread level |
| sev_on_pend_i | input | 1 | Unenabled pending request counts as event |
| irq_req_i | input | N_IRQ | Interrupt request lines |
| irq_en_i | input | N_IRQ | Per-line interrupt enables |
| evt_line_i | input | N_EVT | Event-mode lines |
| clk_en_o | output | 1 | Core clock-gate enable, low while asleep |
| sleeping_o | output | 1 | Sleep status |
| wake_o | output | 1 | One-cycle wake pulse |

## Verification
The two functions that can fall in the same cycle are sleep entry and wake detection. An entry strobe can coincide with an enabled interrupt request, or a wait-for-event strobe can coincide with an event or an already latched one. The bench drives these collisions on purpose and also as sparse random stimulus. It judges each cycle against a behavioural reference model that must show the entry cancelled and the core still awake. It also checks that the latch is consumed, so the next wait-for-event sleeps.

// File: rtl/slp_pkg.sv
package slp_pkg;
  typedef enum logic {
    KIND_WFI = 1'b0,
    KIND_WFE = 1'b1
  } slp_kind_t;
endpackage

// File: rtl/slp_wake_src.sv
module slp_wake_src #(
  parameter int N_IRQ = 8,
  parameter int N_EVT = 4
) (
  input  logic [N_IRQ-1:0] irq_req_i,
  input  logic [N_IRQ-1:0] irq_en_i,
  input  logic [N_EVT-1:0] evt_line_i,
  input  logic             sev_on_pend_i,
  output logic             irq_wake_o,
  output logic             evt_hit_o
);
  logic [N_IRQ-1:0] en_hit;
  logic [N_IRQ-1:0] pend_hit;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_line
    assign en_hit[i]   = irq_req_i[i] & irq_en_i[i];
    assign pend_hit[i] = irq_req_i[i] & ~irq_en_i[i] & sev_on_pend_i;
  end

  assign irq_wake_o = |en_hit;
  assign evt_hit_o  = (|evt_line_i) | (|pend_hit);
endmodule

// File: rtl/slp_evt_latch.sv
module slp_evt_latch (
  input  logic clk,
  input  logic rst,
  input  logic evt_hit_i,
  input  logic consume_i,
  output logic latch_o
);
  logic latch_q;

  always_ff @(posedge clk) begin
    if (rst)            latch_q <= 1'b0;
    else if (consume_i) latch_q <= 1'b0;
    else if (evt_hit_i) latch_q <= 1'b1;
  end

  assign latch_o = latch_q;
endmodule

// File: rtl/slp_core_fsm.sv
module slp_core_fsm
  import slp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wfi_i,
  input  logic wfe_i,
  input  logic soe_ret_i,
  input  logic irq_wake_i,
  input  logic evt_hit_i,
  input  logic latch_i,
  output logic sleeping_o,
  output logic clk_en_o,
  output logic wake_o,
  output logic consume_o
);
  logic      sleeping_q, clk_en_q, wake_q;
  slp_kind_t kind_q;
  logic      sel_wfe, enter_req, cancel, wake_cond, wfe_take, wfe_wake;

  assign sel_wfe   = wfe_i & ~wfi_i;
  assign enter_req = wfi_i | wfe_i | soe_ret_i;
  assign cancel    = irq_wake_i | (sel_wfe & (latch_i | evt_hit_i));
  assign wake_cond = (kind_q == KIND_WFE) ? evt_hit_i : irq_wake_i;
  assign wfe_take  = ~sleeping_q & sel_wfe;
  assign wfe_wake  = sleeping_q & (kind_q == KIND_WFE) & evt_hit_i;
  assign consume_o = wfe_take | wfe_wake;

  always_ff @(posedge clk) begin
    if (rst) begin
      sleeping_q <= 1'b0;
      clk_en_q   <= 1'b1;
      wake_q     <= 1'b0;
      kind_q     <= KIND_WFI;
    end else if (!sleeping_q) begin
      wake_q <= 1'b0;
      if (enter_req && !cancel) begin
        sleeping_q <= 1'b1;
        clk_en_q   <= 1'b0;
        kind_q     <= sel_wfe ? KIND_WFE : KIND_WFI;
      end
    end else begin
      if (wake_cond) begin
        sleeping_q <= 1'b0;
        clk_en_q   <= 1'b1;
        wake_q     <= 1'b1;
      end else begin
        wake_q <= 1'b0;
      end
    end
  end

  assign sleeping_o = sleeping_q;
  assign clk_en_o   = clk_en_q;
  assign wake_o     = wake_q;

  // R7
  wake_single_chk: assert property (@(posedge clk) disable iff (rst)
    wake_q |=> !wake_q);
  // R7
  wake_gate_chk: assert property (@(posedge clk) disable iff (rst)
    wake_q |-> (clk_en_q && !sleeping_q));
  // R9
  entry_cancel_chk: assert property (@(posedge clk) disable iff (rst)
    (!sleeping_q && irq_wake_i) |=> !sleeping_q);
  // R4
  wfi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sleeping_q && kind_q == KIND_WFI && !irq_wake_i) |=> sleeping_q);
  // R5
  wfe_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sleeping_q && kind_q == KIND_WFE && !evt_hit_i) |=> sleeping_q);
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl #(
  parameter int N_IRQ = 8,
  parameter int N_EVT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wfi_i,
  input  logic             wfe_i,
  input  logic             isr_ret_i,
  input  logic             ret_thread_i,
  input  logic             sleep_on_exit_i,
  input  logic             sev_on_pend_i,
  input  logic [N_IRQ-1:0] irq_req_i,
  input  logic [N_IRQ-1:0] irq_en_i,
  input  logic [N_EVT-1:0] evt_line_i,
  output logic             clk_en_o,
  output logic             sleeping_o,
  output logic             wake_o
);
  logic irq_wake, evt_hit, latch_q, consume, soe_ret;

  assign soe_ret = isr_ret_i & ret_thread_i & sleep_on_exit_i;

  slp_wake_src #(.N_IRQ(N_IRQ), .N_EVT(N_EVT)) u_src (
    .irq_req_i     (irq_req_i),
    .irq_en_i      (irq_en_i),
    .evt_line_i    (evt_line_i),
    .sev_on_pend_i (sev_on_pend_i),
    .irq_wake_o    (irq_wake),
    .evt_hit_o     (evt_hit)
  );

  slp_evt_latch u_latch (
    .clk       (clk),
    .rst       (rst),
    .evt_hit_i (evt_hit),
    .consume_i (consume),
    .latch_o   (latch_q)
  );

  slp_core_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .wfi_i      (wfi_i),
    .wfe_i      (wfe_i),
    .soe_ret_i  (soe_ret),
    .irq_wake_i (irq_wake),
    .evt_hit_i  (evt_hit),
    .latch_i    (latch_q),
    .sleeping_o (sleeping_o),
    .clk_en_o   (clk_en_o),
    .wake_o     (wake_o),
    .consume_o  (consume)
  );

  // R8
  latch_fallthru_chk: assert property (@(posedge clk) disable iff (rst)
    (!sleeping_o && wfe_i && !wfi_i && latch_q) |=> (!sleeping_o && !latch_q));
  // R7
  wake_after_sleep_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wake_o) |-> $past(sleeping_o));
  // R10
  ignore_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (sleeping_o && !irq_wake && !evt_hit) |=> sleeping_o);
endmodule

// File: tb/sleep_wake_ctrl_test.sv
module sleep_wake_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 8;
  localparam int NE = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wfi = 0, wfe = 0, iret = 0, thr = 0, soe = 0, sev = 0;
  logic [NI-1:0] req = '0, en = '0;
  logic [NE-1:0] evt = '0;
  logic clk_en, sleeping, wake;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sleep_wake_ctrl #(.N_IRQ(NI), .N_EVT(NE)) uut (
    .clk(clk), .rst(rst), .wfi_i(wfi), .wfe_i(wfe), .isr_ret_i(iret),
    .ret_thread_i(thr), .sleep_on_exit_i(soe), .sev_on_pend_i(sev),
    .irq_req_i(req), .irq_en_i(en), .evt_line_i(evt),
    .clk_en_o(clk_en), .sleeping_o(sleeping), .wake_o(wake)
  );

  // Behavioural reference model
  bit m_sleep = 0, m_kind_evt = 0, m_latch = 0, m_wake = 0;
  always @(posedge clk) begin
    bit irqw, ev;
    irqw = (req & en) != 0;
    ev   = (evt != 0) || (sev && ((req & ~en) != 0));
    if (rst) begin
      m_sleep = 0; m_kind_evt = 0; m_latch = 0; m_wake = 0;
    end else if (m_sleep) begin
      if (m_kind_evt ? ev : irqw) begin
        m_sleep = 0; m_wake = 1;
        if (m_kind_evt) m_latch = 0;
        else if (ev) m_latch = 1;
      end else begin
        m_wake = 0;
        if (ev) m_latch = 1;
      end
    end else begin
      m_wake = 0;
      if (wfe && !wfi) begin
        if (!(irqw || m_latch || ev)) begin m_sleep = 1; m_kind_evt = 1; end
        m_latch = 0;
      end else if (wfi || (iret && thr && soe)) begin
        if (!irqw) begin m_sleep = 1; m_kind_evt = 0; end
        if (ev) m_latch = 1;
      end else if (ev) m_latch = 1;
    end
  end

  task automatic chk(input string req_tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", req_tag, what, act, exp);
    end
  endtask

  always @(negedge clk) if (!rst && !done) begin
    chk("R7", "model sleeping", sleeping, m_sleep);
    chk("R7", "model clk_en", clk_en, !m_sleep);
    chk("R7", "model wake", wake, m_wake);
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic expect3(input string r, input logic s, input logic w);
    chk(r, "sleeping", sleeping, s);
    chk(r, "clk_en", clk_en, !s);
    chk(r, "wake", wake, w);
  endtask

  task automatic strobe_wfi(); wfi = 1; tick(); wfi = 0; endtask
  task automatic strobe_wfe(); wfe = 1; tick(); wfe = 0; endtask

  initial begin
    repeat (3) tick();
    rst = 0;
    tick();
    expect3("R1", 0, 0);
    // R2: enter with wfi
    strobe_wfi();
    expect3("R2", 1, 0);
    tick(); expect3("R2", 1, 0);
    // R4: unenabled request and event lines do not wake
    req[2] = 1; tick(); expect3("R4", 1, 0);
    evt[0] = 1; tick(); evt[0] = 0; expect3("R4", 1, 0);
    en[2] = 1; tick(); expect3("R4", 0, 1);
    req[2] = 0; en[2] = 0; tick(); expect3("R7", 0, 0);
    // R8: latch set during interrupt sleep, wfe falls through then sleeps
    strobe_wfe(); expect3("R8", 0, 0);
    strobe_wfe(); expect3("R8", 1, 0);
    // R5: enabled interrupt does not end event sleep
    req[4] = 1; en[4] = 1; tick(); expect3("R5", 1, 0);
    req[4] = 0; en[4] = 0;
    evt[1] = 1; tick(); evt[1] = 0; expect3("R5", 0, 1);
    tick(); expect3("R7", 0, 0);
    // R8: wake consumed the latch
    strobe_wfe(); expect3("R8", 1, 0);
    // R6: pending-unenabled counts as event only with sev set
    req[0] = 1; tick(); expect3("R6", 1, 0);
    sev = 1; tick(); expect3("R6", 0, 1);
    req[0] = 0; sev = 0; tick();
    // R3: sleep-on-exit
    soe = 1; iret = 1; thr = 0; tick(); iret = 0; expect3("R3", 0, 0);
    iret = 1; thr = 1; tick(); iret = 0; thr = 0; expect3("R3", 1, 0);
    req[1] = 1; en[1] = 1; tick(); expect3("R3", 0, 1);
    req[1] = 0; en[1] = 0;
    soe = 0; iret = 1; thr = 1; tick(); iret = 0; thr = 0; expect3("R3", 0, 0);
    // R9: same-cycle cancel
    req[3] = 1; en[3] = 1; wfi = 1; tick(); wfi = 0; req[3] = 0; en[3] = 0;
    expect3("R9", 0, 0);
    evt[2] = 1; wfe = 1; tick(); wfe = 0; evt[2] = 0; expect3("R9", 0, 0);
    strobe_wfe(); expect3("R9", 1, 0);
    evt[3] = 1; tick(); evt[3] = 0; expect3("R9", 0, 1);
    // R10: both strobes give interrupt kind, strobes ignored while asleep
    wfi = 1; wfe = 1; tick(); wfi = 0; wfe = 0; expect3("R10", 1, 0);
    evt[0] = 1; tick(); evt[0] = 0; expect3("R10", 1, 0);
    strobe_wfe(); expect3("R10", 1, 0);
    req[5] = 1; en[5] = 1; tick(); req[5] = 0; en[5] = 0; expect3("R10", 0, 1);
    tick();
    // Random collisions compared against the model
    for (int i = 0; i < 2000; i++) begin
      wfi  = ($urandom % 12) == 0;
      wfe  = ($urandom % 10) == 0;
      iret = ($urandom % 8) == 0;
      thr  = $urandom % 2;
      soe  = $urandom % 2;
      sev  = $urandom % 2;
      req  = (($urandom % 6) == 0) ? NI'(1 << ($urandom % NI)) : '0;
      en   = NI'($urandom);
      evt  = (($urandom % 9) == 0) ? NE'(1 << ($urandom % NE)) : '0;
      tick();
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule